// File: doc/BRIEF.md
# 16-bit PWM Timer Channel

This block is a single timer channel that generates one pulse-width-modulated waveform. A 16-bit counter advances on ticks from a clock prescaler. The counter runs from 0 up to one less than the programmed period, then returns to 0. While the count is below the programmed duty value the waveform is in its active phase. A polarity bit chooses whether the active phase drives the pin high or low.

Software programs the channel through a byte-wide register-write port. The period and the duty value are each written as a low byte and a high byte. Both land in staging registers. The compare registers in use take the staged values only at a counter wrap, while the counter is stopped, or on a counter clear, so a half-written value never shapes a pulse. Each wrap sets a sticky flag, and software clears it by writing 1.

The pin is driven with the waveform only when a pin-enable bit is set and PWM mode is legal. PWM mode is legal only when the external-clock and capture mode bits are both 0. In every other case the pin is held low.

Top module: `pwm16_timer`

## Requirements
- R1: After reset, every register is 0, `pwm_out` is 0 and `period_irq` is 0.
- R2: Register 0 holds the control bits: bit 0 run, bit 1 counter clear, bits 4:2 clock code, bit 5 PWM enable and bit 6 polarity. With run set and clock code 000, the counter steps once per clock from 0 to P-1 and then returns to 0. P is the active period, which is register 3 (high byte) and register 2 (low byte). Successive wraps are therefore P clocks apart.
- R3: Clock code c, for c from 0 to 6, makes one counter step every 2^c clocks. Successive wraps are then P·2^c clocks apart.
- R4: The active phase lasts while the count is below the active duty D, which is register 5 (high byte) and register 4 (low byte). The pin is high in the active phase when polarity is 1 and low in it when polarity is 0. Over whole periods the active phase takes D clocks out of every P at clock code 000.
- R5: With D = 0 the pin stays at the inactive level. With D >= P the pin stays at the active level.
- R6: Register 1 holds bit 0 pin enable, bit 1 external-clock mode and bit 2 capture mode. The pin is 0 unless pin enable is 1, PWM enable is 1, external-clock mode is 0 and capture mode is 0.
- R7: Clock code 111 freezes the counter, so no wrap occurs.
- R8: Period and duty writes made while the counter runs take effect only at the next wrap. The period in progress keeps its old length.
- R9: A wrap sets `period_irq`, and the flag stays set until bit 0 of a write to register 6 is 1. Writing 0 to that bit leaves the flag set. If a wrap and a clear happen in the same cycle, the flag is set.
- R10: Writing register 0 with bit 1 set puts the counter and the prescaler at 0 at that clock edge. The next period then starts from count 0. The clear bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | PWM pin drive |
| period_irq | output | 1 | Sticky period-wrap flag |

## Verification
The bench sets the duty to the edges of its range: 0, which gives a constant inactive level, and above the period, which gives a constant active level. A design that compared with the wrong relation would produce a one-clock glitch or a missing pulse in each period. The bench rewrites the period mid-run and times the period in progress, which catches a design that loads the compare registers on each write and stretches or cuts that period. It times wraps at several clock codes to catch an off-by-one divider. It also checks the stop code, the write-0 case of the flag clear, and the consecutive active clocks that follow a counter clear.

// File: rtl/pwm16_timer.sv
module pwm16_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out,
  output logic       period_irq
);
  localparam int CW = 16;
  localparam int PW = 6;

  logic          run, pwm_en, pol, pin_en, ext_mode, cap_mode;
  logic [2:0]    clk_sel;
  logic [CW-1:0] per_stage, duty_stage, per_cur, duty_cur, cnt;
  logic [PW-1:0] pre;
  logic          irq_q;

  logic [PW:0]   div_full;
  logic [PW-1:0] div_last;
  logic          counting, tick, wrap, clr_req, irq_clr, below, gate;

  assign div_full = (PW+1)'(1) << clk_sel;
  assign div_last = PW'(div_full - 1'b1);
  assign counting = run && (clk_sel != 3'd7);
  assign tick     = counting && (pre == div_last);
  assign wrap     = tick && ({1'b0, cnt} + 17'd1 >= {1'b0, per_cur});
  assign clr_req  = wr_en && (wr_addr == 3'd0) && wr_data[1];
  assign irq_clr  = wr_en && (wr_addr == 3'd6) && wr_data[0];
  assign below    = cnt < duty_cur;
  assign gate     = pin_en && pwm_en && !ext_mode && !cap_mode;

  assign pwm_out    = gate && (pol ? below : !below);
  assign period_irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      clk_sel    <= 3'd0;
      pwm_en     <= 1'b0;
      pol        <= 1'b0;
      pin_en     <= 1'b0;
      ext_mode   <= 1'b0;
      cap_mode   <= 1'b0;
      per_stage  <= '0;
      duty_stage <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin
          run     <= wr_data[0];
          clk_sel <= wr_data[4:2];
          pwm_en  <= wr_data[5];
          pol     <= wr_data[6];
        end
        3'd1: begin
          pin_en   <= wr_data[0];
          ext_mode <= wr_data[1];
          cap_mode <= wr_data[2];
        end
        3'd2: per_stage[7:0]   <= wr_data;
        3'd3: per_stage[15:8]  <= wr_data;
        3'd4: duty_stage[7:0]  <= wr_data;
        3'd5: duty_stage[15:8] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cur  <= '0;
      duty_cur <= '0;
    end else if (wrap || !run || clr_req) begin
      per_cur  <= per_stage;
      duty_cur <= duty_stage;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (clr_req) begin
      pre <= '0;
      cnt <= '0;
    end else if (counting) begin
      if (tick) begin
        pre <= '0;
        cnt <= wrap ? '0 : cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (wrap)    irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end
endmodule

// File: rtl/pwm16_timer_chk.sv
module pwm16_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        pwm_en,
  input logic        pol,
  input logic        pin_en,
  input logic        ext_mode,
  input logic        cap_mode,
  input logic [2:0]  clk_sel,
  input logic [15:0] cnt,
  input logic [15:0] per_cur,
  input logic [15:0] duty_cur,
  input logic        tick,
  input logic        wrap,
  input logic        clr_req,
  input logic        pwm_out,
  input logic        period_irq
);
  logic en_pin;
  assign en_pin = pin_en && pwm_en && !ext_mode && !cap_mode;

  assert_pin_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |-> !pwm_out);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !clr_req) |=> cnt == $past(cnt) + 16'd1);

  assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr_req) |=> (cnt == 16'd0) && period_irq);

  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd7 && !clr_req) |=> $stable(cnt));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap && !clr_req) |=> ($stable(per_cur) && $stable(duty_cur)));

  assert_duty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && duty_cur == 16'd0) |-> (pwm_out == !pol));
endmodule

bind pwm16_timer pwm16_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pwm_en(pwm_en), .pol(pol),
  .pin_en(pin_en), .ext_mode(ext_mode), .cap_mode(cap_mode),
  .clk_sel(clk_sel), .cnt(cnt), .per_cur(per_cur), .duty_cur(duty_cur),
  .tick(tick), .wrap(wrap), .clr_req(clr_req), .pwm_out(pwm_out),
  .period_irq(period_irq)
);

// File: tb/test_pwm16_timer.sv
`timescale 1ns/1ps
module test_pwm16_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out, period_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm16_timer i_pwm16_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .period_irq(period_irq)
  );

  // behavioural reference model
  int m_run, m_sel, m_pwm, m_pol, m_pin, m_ext, m_cap;
  int m_ps, m_ds, m_pa, m_da, m_pre, m_cnt, m_flag;
  int t_go, t_div, t_tk, t_wr, t_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_sel = 0; m_pwm = 0; m_pol = 0; m_pin = 0; m_ext = 0; m_cap = 0;
      m_ps = 0; m_ds = 0; m_pa = 0; m_da = 0; m_pre = 0; m_cnt = 0; m_flag = 0;
    end else begin
      t_go  = (m_run != 0 && m_sel != 7) ? 1 : 0;
      t_div = 2 ** m_sel;
      t_tk  = (t_go != 0 && m_pre == t_div - 1) ? 1 : 0;
      t_wr  = (t_tk != 0 && m_cnt + 1 >= m_pa) ? 1 : 0;
      t_clr = (wr_en && wr_addr == 3'd0 && wr_data[1]) ? 1 : 0;
      if (t_wr != 0 || m_run == 0 || t_clr != 0) begin m_pa = m_ps; m_da = m_ds; end
      if (t_clr != 0) begin m_pre = 0; m_cnt = 0; end
      else if (t_go != 0) begin
        if (t_tk != 0) begin m_pre = 0; m_cnt = (t_wr != 0) ? 0 : m_cnt + 1; end
        else m_pre = m_pre + 1;
      end
      if (t_wr != 0) m_flag = 1;
      else if (wr_en && wr_addr == 3'd6 && wr_data[0]) m_flag = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_run = wr_data[0]; m_sel = wr_data[4:2]; m_pwm = wr_data[5]; m_pol = wr_data[6]; end
          3'd1: begin m_pin = wr_data[0]; m_ext = wr_data[1]; m_cap = wr_data[2]; end
          3'd2: m_ps = (m_ps & 32'hFF00) | wr_data;
          3'd3: m_ps = (m_ps & 32'h00FF) | (wr_data << 8);
          3'd4: m_ds = (m_ds & 32'hFF00) | wr_data;
          3'd5: m_ds = (m_ds & 32'h00FF) | (wr_data << 8);
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_pin();
    bit act;
    act = m_cnt < m_da;
    if (!(m_pin != 0 && m_pwm != 0 && m_ext == 0 && m_cap == 0)) return 1'b0;
    return (m_pol != 0) ? act : !act;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2-R10 model pwm_out", pwm_out, exp_pin());
      check("R9 model period_irq", period_irq, m_flag);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int per, int duty, int code, int pol, int pin, int ext, int cap);
    wr(3'd2, per[7:0]);  wr(3'd3, per[15:8]);
    wr(3'd4, duty[7:0]); wr(3'd5, duty[15:8]);
    wr(3'd1, {5'd0, cap[0], ext[0], pin[0]});
    wr(3'd0, {1'b0, pol[0], 1'b1, code[2:0], 2'b11});
  endtask

  task automatic count_high(int w, output int n);
    n = 0;
    for (int i = 0; i < w; i++) begin
      if (pwm_out) n++;
      @(negedge clk);
    end
  endtask

  // cycles between two wraps; optionally rewrites the period right after the first
  task automatic measure(output int k, input bit rewrite, input int newp);
    int g;
    g = 0;
    while (!period_irq && g < 20000) begin @(negedge clk); g++; end
    wr(3'd6, 8'h01); k = 1;
    if (rewrite) begin
      wr(3'd2, newp[7:0]);  k++;
      wr(3'd3, newp[15:8]); k++;
    end
    while (!period_irq && k < 20000) begin @(negedge clk); k++; end
  endtask

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    check("R1 reset pwm_out", pwm_out, 0);
    check("R1 reset period_irq", period_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle pwm_out", pwm_out, 0);

    cfg(20, 5, 0, 1, 1, 0, 0);
    measure(k, 1'b0, 0); check("R2 period 20 code0", k, 20);
    measure(k, 1'b0, 0); check("R2 period 20 again", k, 20);

    cfg(10, 3, 1, 1, 1, 0, 0);
    measure(k, 1'b0, 0); check("R3 code1 period 10", k, 20);
    cfg(10, 3, 3, 1, 1, 0, 0);
    measure(k, 1'b0, 0); check("R3 code3 period 10", k, 80);
    cfg(4, 1, 6, 1, 1, 0, 0);
    measure(k, 1'b0, 0); check("R3 code6 period 4", k, 256);

    cfg(10, 3, 0, 1, 1, 0, 0);
    count_high(100, n); check("R4 pol1 high clocks", n, 30);
    cfg(10, 3, 0, 0, 1, 0, 0);
    count_high(100, n); check("R4 pol0 high clocks", n, 70);

    cfg(10, 0, 0, 1, 1, 0, 0);
    count_high(100, n); check("R5 duty zero", n, 0);
    cfg(10, 50, 0, 1, 1, 0, 0);
    count_high(100, n); check("R5 duty above period", n, 100);
    cfg(10, 10, 0, 0, 1, 0, 0);
    count_high(100, n); check("R5 duty equal period pol0", n, 0);

    cfg(10, 5, 0, 1, 0, 0, 0);
    count_high(50, n); check("R6 pin disabled", n, 0);
    cfg(10, 5, 0, 1, 1, 1, 0);
    count_high(50, n); check("R6 external mode", n, 0);
    cfg(10, 5, 0, 1, 1, 0, 1);
    count_high(50, n); check("R6 capture mode", n, 0);
    cfg(10, 5, 0, 1, 1, 0, 0);
    count_high(50, n); check("R6 enabled again", n, 25);

    cfg(5, 2, 7, 1, 1, 0, 0);
    wr(3'd6, 8'h01);
    count_high(200, n);
    check("R7 stopped no wrap", period_irq, 0);
    check("R7 stopped level", n, 200);

    cfg(30, 10, 0, 1, 1, 0, 0);
    measure(k, 1'b1, 12); check("R8 old period kept", k, 30);
    measure(k, 1'b0, 0);  check("R8 new period used", k, 12);

    cfg(1000, 10, 0, 1, 1, 0, 0);
    while (!period_irq) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R9 flag sticky", period_irq, 1);
    wr(3'd6, 8'h00);
    check("R9 write 0 keeps flag", period_irq, 1);
    wr(3'd6, 8'h01);
    check("R9 write 1 clears flag", period_irq, 0);

    cfg(100, 50, 0, 1, 1, 0, 0);
    repeat (37) @(negedge clk);
    wr(3'd0, 8'b0110_0011);
    n = 0;
    while (pwm_out && n < 200) begin n++; @(negedge clk); end
    check("R10 active run after clear", n, 50);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule